// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. It steers three analog switches around an external integrator: one routes the unknown input into the integrator, one routes a reference of opposite polarity, and one discharges the integrator. It watches a single comparator bit that tells whether the integrator output is still above zero. From these it produces a binary code proportional to the ratio of input to reference.

A one-cycle start request begins a conversion. The integrator is first held in discharge for a short auto-zero window. The input is then integrated for a fixed number of clock cycles, which is chosen as a whole number of mains periods so that hum cancels. The reference then ramps the integrator back down while a counter runs from zero. The count taken when the integrator reaches zero is the result. If no crossing arrives within a full-scale limit, the conversion ends with an overflow flag and an all-ones code.

Top module: `dslope_adc_ctrl`

## Requirements
- R1: After an accepted start, the discharge switch stays on for exactly AZ_CYCLES cycles. The input switch then stays on for exactly T_CYCLES cycles.
- R2: The reference switch turns on in the cycle directly after the input switch turns off. At most one of the three switches is on in any cycle.
- R3: The comparator bit is 1 while the integrator is above zero. It passes through SYNC_STAGES flops. The result is the de-integration count at the first synchronised 0, minus SYNC_STAGES. For an integrator that gains VIN per input cycle and loses VREF per reference cycle, this equals ceil(T_CYCLES*VIN/VREF).
- R4: A count equal to MAX_CNT is still a valid result. If the crossing is not seen by then, the conversion ends with overflow_o = 1 and result_o all ones.
- R5: done_o is high for exactly one cycle per conversion, in the first cycle that shows the new result_o. overflow_o keeps its value until the next accepted start clears it.
- R6: A start request while busy_o is high is ignored. The running conversion keeps its timing and its result, and no extra conversion follows.
- R7: When de-integration ends, the discharge switch turns on at once. It stays on for as long as the block is idle.
- R8: During and after reset the outputs are as follows: discharge switch on, input and reference switches off, busy_o 0, done_o 0, overflow_o 0, result_o 0.
- R9: A zero input gives a result of 0 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| cmp_i | input | 1 | Comparator, 1 while integrator output is above zero (asynchronous) |
| sw_input_o | output | 1 | Connect unknown input to integrator |
| sw_ref_o | output | 1 | Connect opposite-polarity reference to integrator |
| sw_reset_o | output | 1 | Discharge the integrator |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| overflow_o | output | 1 | Last conversion found no crossing within MAX_CNT |
| result_o | output | RES_W | Converted code |

## Verification
The bench builds the block with T_CYCLES = 20, AZ_CYCLES = 3, MAX_CNT = 40, SYNC_STAGES = 2 and RES_W = 8. These values keep each conversion under about seventy cycles. At this size a behavioural integrator with integer steps can place the crossing exactly at the full-scale count and one step past it. The same run also covers a zero input, a ratio that does not divide evenly, and a start pulse that arrives in the middle of integration.

// File: rtl/ds_adc_pkg.sv
package ds_adc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_AZERO = 2'd1,
      PH_INTEG = 2'd2,
      PH_DEINT = 2'd3
   } phase_t;
endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ds_phase_cnt.sv
module ds_phase_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else          q <= q + 1'b1;
   end
endmodule

// File: rtl/ds_sequencer.sv
module ds_sequencer
   import ds_adc_pkg::*;
#(
   parameter int T_CYCLES    = 64,
   parameter int AZ_CYCLES   = 4,
   parameter int MAX_CNT     = 128,
   parameter int SYNC_STAGES = 2,
   parameter int RES_W       = 8,
   parameter int CW          = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_s,
   input  logic [CW-1:0]    cnt_q,
   output logic             cnt_clr,
   output phase_t           phase_o,
   output logic [RES_W-1:0] result_o,
   output logic             done_o,
   output logic             overflow_o
);
   localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_CYCLES - 1);
   localparam logic [CW-1:0] INT_LAST = CW'(T_CYCLES - 1);
   localparam logic [CW-1:0] SYNC_LAT = CW'(SYNC_STAGES);
   localparam logic [CW-1:0] LIMIT    = CW'(MAX_CNT + SYNC_STAGES);

   phase_t        phase_q, phase_d;
   logic          zero_hit, limit_hit, finish;
   logic [CW-1:0] corrected;

   // Comparator is stale for SYNC_STAGES cycles after the switch-over.
   assign zero_hit  = (phase_q == PH_DEINT) && (cnt_q >= SYNC_LAT) && !cmp_s;
   assign limit_hit = (phase_q == PH_DEINT) && (cnt_q == LIMIT);
   assign finish    = zero_hit || limit_hit;
   assign corrected = cnt_q - SYNC_LAT;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (start_i)           phase_d = PH_AZERO;
         PH_AZERO: if (cnt_q == AZ_LAST)  phase_d = PH_INTEG;
         PH_INTEG: if (cnt_q == INT_LAST) phase_d = PH_DEINT;
         PH_DEINT: if (finish)            phase_d = PH_IDLE;
         default:                         phase_d = PH_IDLE;
      endcase
   end

   assign cnt_clr = (phase_d != phase_q) || (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         result_o   <= '0;
         done_o     <= 1'b0;
         overflow_o <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_o  <= finish;
         if ((phase_q == PH_IDLE) && start_i) begin
            overflow_o <= 1'b0;
         end else if (zero_hit) begin
            result_o   <= RES_W'(corrected);
            overflow_o <= 1'b0;
         end else if (limit_hit) begin
            result_o   <= '1;
            overflow_o <= 1'b1;
         end
      end
   end

   assign phase_o = phase_q;
endmodule

// File: rtl/dslope_adc_ctrl.sv
module dslope_adc_ctrl
   import ds_adc_pkg::*;
#(
   parameter int T_CYCLES    = 64,
   parameter int AZ_CYCLES   = 4,
   parameter int MAX_CNT     = 2 * T_CYCLES,
   parameter int SYNC_STAGES = 2,
   parameter int RES_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic             sw_input_o,
   output logic             sw_ref_o,
   output logic             sw_reset_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             overflow_o,
   output logic [RES_W-1:0] result_o
);
   localparam int TOP_A  = (T_CYCLES > AZ_CYCLES) ? T_CYCLES : AZ_CYCLES;
   localparam int TOP_B  = MAX_CNT + SYNC_STAGES;
   localparam int CNT_MX = (TOP_A > TOP_B) ? TOP_A : TOP_B;
   localparam int CW     = $clog2(CNT_MX + 1);

   generate
      if (T_CYCLES < 1) begin : g_bad_t
         $error("T_CYCLES must be at least 1");
      end
      if (AZ_CYCLES < 1) begin : g_bad_az
         $error("AZ_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MAX_CNT >= (2 ** RES_W) - 1) begin : g_bad_w
         $error("RES_W too narrow: full-scale code must exceed MAX_CNT");
      end
   endgenerate

   logic          cmp_s;
   logic          cnt_clr;
   logic [CW-1:0] cnt_q;
   phase_t        phase;

   ds_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_i),
      .q     (cmp_s)
   );

   ds_phase_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .q     (cnt_q)
   );

   ds_sequencer #(
      .T_CYCLES    (T_CYCLES),
      .AZ_CYCLES   (AZ_CYCLES),
      .MAX_CNT     (MAX_CNT),
      .SYNC_STAGES (SYNC_STAGES),
      .RES_W       (RES_W),
      .CW          (CW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cmp_s      (cmp_s),
      .cnt_q      (cnt_q),
      .cnt_clr    (cnt_clr),
      .phase_o    (phase),
      .result_o   (result_o),
      .done_o     (done_o),
      .overflow_o (overflow_o)
   );

   assign sw_input_o = (phase == PH_INTEG);
   assign sw_ref_o   = (phase == PH_DEINT);
   assign sw_reset_o = (phase == PH_IDLE) || (phase == PH_AZERO);
   assign busy_o     = (phase != PH_IDLE);
endmodule

// File: rtl/ds_adc_checker.sv
module ds_adc_checker #(
   parameter int T_CYCLES = 64,
   parameter int RES_W    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             sw_input_o,
   input logic             sw_ref_o,
   input logic             sw_reset_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             overflow_o,
   input logic [RES_W-1:0] result_o
);
   int run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run <= 0;
      else if (sw_input_o) run <= run + 1;
      else                 run <= 0;
   end

   assert_integ_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_input_o) |-> (run == T_CYCLES));
   assert_switch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_input_o, sw_ref_o, sw_reset_o}));
   assert_ref_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_ref_o) |-> $past(sw_input_o));
   assert_ovf_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && overflow_o) |-> (result_o == {RES_W{1'b1}}));
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_input_o && start_i) |=> (sw_input_o || sw_ref_o));
   assert_reset_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_ref_o) |-> sw_reset_o);
   assert_idle_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> sw_reset_o);
endmodule

bind dslope_adc_ctrl ds_adc_checker #(
   .T_CYCLES (T_CYCLES),
   .RES_W    (RES_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .sw_input_o (sw_input_o),
   .sw_ref_o   (sw_ref_o),
   .sw_reset_o (sw_reset_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .overflow_o (overflow_o),
   .result_o   (result_o)
);

// File: tb/tb_dslope_adc_ctrl.sv
`timescale 1ns/1ps
module tb_dslope_adc_ctrl;
   localparam int T    = 20;
   localparam int AZ   = 3;
   localparam int MAXC = 40;
   localparam int SYNC = 2;
   localparam int RW   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cmp;
   logic sw_in, sw_ref, sw_rst, busy, done, ovf;
   logic [RW-1:0] res;

   int checks = 0;
   int fails  = 0;
   int acc    = 0;
   int vin_m  = 0;
   int vref_m = 1;
   int q_res[$];
   int q_ovf[$];

   always #5 clk = ~clk;

   dslope_adc_ctrl #(
      .T_CYCLES(T), .AZ_CYCLES(AZ), .MAX_CNT(MAXC),
      .SYNC_STAGES(SYNC), .RES_W(RW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
      .sw_input_o(sw_in), .sw_ref_o(sw_ref), .sw_reset_o(sw_rst),
      .busy_o(busy), .done_o(done), .overflow_o(ovf), .result_o(res)
   );

   // Behavioural integrator
   always @(posedge clk) begin
      if (sw_rst)      acc <= 0;
      else if (sw_in)  acc <= acc + vin_m;
      else if (sw_ref) acc <= acc - vref_m;
   end
   assign cmp = (acc > 0);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: scoreboard plus switch timing
   initial begin
      int in_run = 0;
      int az_run = 0;
      bit prev_in = 0, prev_ref = 0, prev_done = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done) begin
               if (q_res.size() == 0) begin
                  check(0, "R6 extra done", res, -1);
               end else begin
                  int er, eo;
                  er = q_res.pop_front();
                  eo = q_ovf.pop_front();
                  check(res == RW'(er), "R3/R4 result", res, er);
                  check(ovf == eo[0], "R4 overflow flag", ovf, eo);
               end
               if (prev_done) check(0, "R5 done longer than one cycle", 1, 0);
            end
            if (sw_in && !prev_in) check(az_run == AZ, "R1 auto-zero length", az_run, AZ);
            if (!sw_in && prev_in) check(in_run == T, "R1 integration length", in_run, T);
            if (sw_ref && !prev_ref) check(prev_in && !sw_in, "R2 reference follows input", prev_in, 1);
            if (!sw_ref && prev_ref) check(sw_rst, "R7 discharge after de-integration", sw_rst, 1);
            if ((sw_in + sw_ref + sw_rst) > 1) check(0, "R2 switch overlap", sw_in + sw_ref + sw_rst, 1);
            in_run = sw_in ? in_run + 1 : 0;
            az_run = (busy && sw_rst) ? az_run + 1 : 0;
            prev_in = sw_in; prev_ref = sw_ref; prev_done = done;
         end
      end
   end

   function automatic void expect_of(input int vin, input int vref, output int r, output int o);
      int n;
      n = (T * vin + vref - 1) / vref;
      if (n > MAXC) begin r = (1 << RW) - 1; o = 1; end
      else          begin r = n; o = 0; end
   endfunction

   task automatic convert(input int vin, input int vref, input bit glitch);
      int r, o;
      expect_of(vin, vref, r, o);
      vin_m = vin; vref_m = vref;
      q_res.push_back(r);
      q_ovf.push_back(o);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (glitch) begin
         repeat (AZ + 5) @(negedge clk);
         start = 1'b1;              // R6: request while busy
         @(negedge clk) start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(!busy, "R6 no extra conversion", busy, 0);
      check(ovf == o[0], "R5 overflow held", ovf, o);
      check(sw_rst && !sw_in && !sw_ref, "R7 idle discharge", sw_rst, 1);
   endtask

   initial begin
      #2_000_000;
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      check(sw_rst == 1, "R8 discharge on in reset", sw_rst, 1);
      check(!sw_in && !sw_ref, "R8 switches off in reset", sw_in + sw_ref, 0);
      check(!busy && !done && !ovf, "R8 flags clear in reset", busy + done + ovf, 0);
      check(res == 0, "R8 result zero in reset", res, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && sw_rst, "R8 idle after reset", busy, 0);

      convert(5, 10, 0);   // R3 -> 10
      convert(7, 10, 0);   // R3 -> 14
      convert(0, 10, 0);   // R9 -> 0
      convert(3, 7, 1);    // R3 uneven ratio -> 9, R6 start while busy
      convert(20, 10, 0);  // R4 exactly full scale -> 40
      convert(21, 10, 0);  // R4 overflow -> 255
      convert(5, 10, 0);   // R5 overflow cleared by next start

      check(q_res.size() == 0, "R5 one done per conversion", q_res.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule